// File: doc/BRIEF.md
# Presettable Counter with Dual Count Enables

This block is a small synchronous binary up-counter (four bits by default) that can be preset from a parallel word, cleared by an active-low reset and gated by two separate count-enable inputs. One enable, `cnt_en_t`, also qualifies the terminal-count output. This lets several copies share one clock and be chained into a wider synchronous counter. Each stage's terminal-count flag feeds the next stage's `cnt_en_t`, while a common `cnt_en_p` pauses the whole chain.

A build parameter picks how reset acts. In one variant reset clears the count at the next rising clock edge. In the other it clears the count at once, whatever the clock is doing. The synchronous variant can serve as a modulo-N divider: external logic decodes count N-1 back into reset, and the sequence has no glitch state.

Top module: `presettable_counter`

## Requirements
- R1: When counting, the value goes up by one in binary on each rising clock edge and wraps from all ones (15 at the default width) to zero.
- R2: With `ASYNC_RST` = 0, a low `rst_n` clears the count at the next rising edge. The count does not change before that edge.
- R3: With `rst_n` high and `load_n` low, a rising edge copies `preset` into `count` bit for bit. `preset[0]` lands in `count[0]`, the least significant bit.
- R4: The count advances only when `load_n`, `cnt_en_p` and `cnt_en_t` are all high at the rising edge.
- R5: With `load_n` high and either enable low, the count keeps its value across the edge.
- R6: `tc_out` is high exactly when `cnt_en_t` is high and the count is all ones. `cnt_en_p` and `load_n` have no effect on it.
- R7: Reset takes priority over load, and load takes priority over counting, whatever the enable levels.
- R8: `tc_out` follows `cnt_en_t` within the same cycle, with no clock edge in between.
- R9: With `ASYNC_RST` = 1, a low `rst_n` clears the count at once without a clock edge. After release, the count stays zero until the next rising edge, which then applies the normal load or count rule.
- R10: Three stages on one clock form a 12-bit counter when each `tc_out` drives the next stage's `cnt_en_t` and all stages share `cnt_en_p`. The combined value then goes up by one per enabled clock and wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, synchronous or asynchronous according to `ASYNC_RST` |
| load_n | input | 1 | Active-low parallel preset strobe |
| preset | input | WIDTH | Value copied into the count on a load |
| cnt_en_p | input | 1 | Count enable that does not affect the terminal-count flag |
| cnt_en_t | input | 1 | Count enable that also gates the terminal-count flag |
| count | output | WIDTH | Present count value |
| tc_out | output | 1 | Terminal-count flag for chaining stages |

## Verification
A corrupted next-state choice shows on `count` right after the next rising edge. A wrong priority turns a load into a count, or a reset into a load, within one cycle. A bad carry term shows up at once on `tc_out` when `cnt_en_t` toggles. In a chain it appears as a missed or doubled step in the upper stage on the cycle after the lower stage wraps. A fault in the reset path of either variant shows within one edge: the count is not zero after reset, or it is cleared too early in the synchronous variant. In the modulo-N divider it shows as a count value of N or more.

// File: rtl/pcnt_pkg.sv
// Shared types for the presettable counter.
// Assumes: one operation is chosen per clock edge.
package pcnt_pkg;

    // Operation applied to the count at the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } pcnt_op_e;

endpackage

// File: rtl/pcnt_ctl.sv
// Control decoder: turns reset, load and both enables into one operation.
// Fixed priority: clear, then load, then count, otherwise hold.
// Assumes: all inputs are synchronous to the counter clock.
module pcnt_ctl
    import pcnt_pkg::*;
(
    input  logic     rst_n,
    input  logic     load_n,
    input  logic     cnt_en_p,
    input  logic     cnt_en_t,
    output pcnt_op_e op
);

    // Pick the operation by priority.
    always_comb begin
        if (!rst_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (cnt_en_p && cnt_en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/pcnt_next.sv
// Next-state datapath: computes the value the register takes at the edge.
// Assumes: the operation comes from pcnt_ctl; the increment wraps modulo 2**WIDTH.
module pcnt_next
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  pcnt_op_e         op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Select the next count from the operation.
    always_comb begin
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/pcnt_reg.sv
// Count register. ASYNC_RST picks whether rst_n clears it at once
// or at the next rising edge.
// Assumes: rst_n is glitch-free when ASYNC_RST is set.
module pcnt_reg #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (ASYNC_RST) begin : g_async
            // Clear immediately on reset, otherwise take the next value.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_sync
            // Clear on the edge while reset is low, otherwise take the next value.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/pcnt_carry.sv
// Terminal-count flag: high when enable T is high and every count bit is one.
// Assumes: cur comes straight from the register; the output is combinational.
module pcnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             cnt_en_t,
    output logic             tc
);

    localparam logic [WIDTH-1:0] TERMINAL = '1;

    // Flag the terminal state, gated by enable T only.
    always_comb tc = cnt_en_t && (cur == TERMINAL);

endmodule

// File: rtl/presettable_counter.sv
// Presettable up-counter with two count enables and a terminal-count flag.
// Top level: connects the decoder, datapath, register and carry logic.
// Assumes: single clock domain; cnt_en_t of a later stage is driven by tc_out.
module presettable_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             cnt_en_p,
    input  logic             cnt_en_t,
    output logic [WIDTH-1:0] count,
    output logic             tc_out
);

    pcnt_op_e         op;
    logic [WIDTH-1:0] nxt;

    pcnt_ctl u_ctl (
        .rst_n    (rst_n),
        .load_n   (load_n),
        .cnt_en_p (cnt_en_p),
        .cnt_en_t (cnt_en_t),
        .op       (op)
    );

    pcnt_next #(.WIDTH(WIDTH)) u_next (
        .op     (op),
        .cur    (count),
        .preset (preset),
        .nxt    (nxt)
    );

    pcnt_reg #(.WIDTH(WIDTH), .ASYNC_RST(ASYNC_RST)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (count)
    );

    pcnt_carry #(.WIDTH(WIDTH)) u_carry (
        .cur      (count),
        .cnt_en_t (cnt_en_t),
        .tc       (tc_out)
    );

endmodule

// File: rtl/presettable_counter_chk.sv
// Checker for presettable_counter: relates port values across clock edges.
// Assumes: bound to every instance of the top module.
module presettable_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic [WIDTH-1:0] preset,
    input logic             cnt_en_p,
    input logic             cnt_en_t,
    input logic [WIDTH-1:0] count,
    input logic             tc_out
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    assert_reset_clears_R2: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(preset));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_p && cnt_en_t) |=> count == WIDTH'($past(count) + 1'b1));

    assert_hold_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

    assert_carry_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> (count == ALL_ONES && cnt_en_t));

    assert_carry_needs_t_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_t |-> !tc_out);

    assert_release_zero_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> count == '0);

endmodule

bind presettable_counter presettable_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .preset   (preset),
    .cnt_en_p (cnt_en_p),
    .cnt_en_t (cnt_en_t),
    .count    (count),
    .tc_out   (tc_out)
);

// File: tb/presettable_counter_tb.sv
`timescale 1ns/1ps
// Bench: synchronous and asynchronous variants side by side, a three-stage
// chain, and a modulo-N divider built on the synchronous variant.
module presettable_counter_tb;

    localparam int DIV_N = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // Stimulus shared by the two single-stage instances
    logic       rst_s, rst_a, load_n, en_p, en_t;
    logic [3:0] preset;
    logic [3:0] cnt_s, cnt_a;
    logic       car_s, car_a;

    presettable_counter #(.WIDTH(4), .ASYNC_RST(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_s), .load_n(load_n), .preset(preset),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .count(cnt_s), .tc_out(car_s));

    presettable_counter #(.WIDTH(4), .ASYNC_RST(1'b1)) u_async (
        .clk(clk), .rst_n(rst_a), .load_n(load_n), .preset(preset),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .count(cnt_a), .tc_out(car_a));

    // Three-stage chain
    logic       rst_c, chain_en;
    logic [3:0] c0, c1, c2;
    logic       k0, k1, k2;

    presettable_counter u_stage0 (.clk(clk), .rst_n(rst_c), .load_n(1'b1), .preset(4'd0),
        .cnt_en_p(chain_en), .cnt_en_t(chain_en), .count(c0), .tc_out(k0));
    presettable_counter u_stage1 (.clk(clk), .rst_n(rst_c), .load_n(1'b1), .preset(4'd0),
        .cnt_en_p(chain_en), .cnt_en_t(k0), .count(c1), .tc_out(k1));
    presettable_counter u_stage2 (.clk(clk), .rst_n(rst_c), .load_n(1'b1), .preset(4'd0),
        .cnt_en_p(chain_en), .cnt_en_t(k1), .count(c2), .tc_out(k2));

    // Modulo-N divider: count N-1 is decoded back into reset
    logic       rst_d;
    logic [3:0] cnt_d;
    logic       car_d;
    logic       div_rst_n;
    assign div_rst_n = rst_d && (cnt_d != 4'(DIV_N - 1));

    presettable_counter u_div (.clk(clk), .rst_n(div_rst_n), .load_n(1'b1), .preset(4'd0),
        .cnt_en_p(1'b1), .cnt_en_t(1'b1), .count(cnt_d), .tc_out(car_d));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(900_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int exp;
        int ref12;
        rst_s = 0; rst_a = 0; load_n = 1; en_p = 0; en_t = 0; preset = 0;
        rst_c = 0; chain_en = 0; rst_d = 0;
        tick(); tick();
        chk(cnt_s == 0, "R2 reset state", cnt_s, 0);
        chk(cnt_a == 0, "R9 reset state", cnt_a, 0);
        chk(car_s == 0, "R6 carry in reset", car_s, 0);
        rst_s = 1; rst_a = 1;

        // R3: every preset value, enables in all patterns (R7: load beats count)
        for (int v = 0; v < 16; v++) begin
            load_n = 0; preset = 4'(v); en_p = v[0]; en_t = v[1];
            tick();
            chk(cnt_s == 4'(v), "R3 load sync", cnt_s, v);
            chk(cnt_a == 4'(v), "R3 load async", cnt_a, v);
            chk(car_s == (v[1] && v == 15), "R6 carry with load low", car_s, int'(v[1] && v == 15));
        end

        // R1/R4: count sweep with wrap
        load_n = 0; preset = 0; tick();
        load_n = 1; en_p = 1; en_t = 1;
        exp = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            exp = (exp + 1) % 16;
            chk(cnt_s == 4'(exp), "R1 R4 count step", cnt_s, exp);
            chk(car_s == (exp == 15), "R6 carry at max", car_s, int'(exp == 15));
        end

        // R5/R6/R8: hold patterns at the terminal value
        load_n = 0; preset = 4'd15; tick();
        load_n = 1; en_p = 0; en_t = 1; #1;
        chk(car_s == 1, "R6 carry ignores en_p", car_s, 1);
        tick();
        chk(cnt_s == 15, "R5 hold en_p low", cnt_s, 15);
        en_p = 1; en_t = 0; #1;
        chk(car_s == 0, "R8 carry drops with en_t", car_s, 0);
        tick();
        chk(cnt_s == 15, "R5 hold en_t low", cnt_s, 15);
        en_p = 0; en_t = 0; tick();
        chk(cnt_s == 15, "R5 hold both low", cnt_s, 15);
        en_p = 1; en_t = 1; #1;
        chk(car_s == 1, "R8 carry rises with en_t", car_s, 1);
        tick();
        chk(cnt_s == 0, "R1 wrap to zero", cnt_s, 0);

        // R7: load over count, reset over load
        load_n = 0; preset = 4'd9; tick();
        chk(cnt_s == 9, "R7 load beats count", cnt_s, 9);
        rst_s = 0; rst_a = 0; preset = 4'd6; #1;
        chk(cnt_a == 0, "R9 async clears at once", cnt_a, 0);
        chk(cnt_s == 9, "R2 sync waits for edge", cnt_s, 9);
        tick();
        chk(cnt_s == 0, "R7 reset beats load", cnt_s, 0);
        load_n = 1; en_p = 1; en_t = 1;
        rst_a = 1; #1;
        chk(cnt_a == 0, "R9 zero after release", cnt_a, 0);
        tick();
        chk(cnt_a == 1, "R9 counts at next edge", cnt_a, 1);
        chk(cnt_s == 0, "R2 held in reset", cnt_s, 0);
        rst_s = 1; tick();
        chk(cnt_s == 1, "R4 count after release", cnt_s, 1);

        // R10: three-stage chain against a 12-bit reference
        rst_c = 1; ref12 = 0;
        for (int i = 0; i < 5000; i++) begin
            chain_en = (i % 9) != 8;
            tick();
            if (chain_en) ref12 = (ref12 + 1) % 4096;
            chk({c2, c1, c0} == 12'(ref12), "R10 chain value", int'({c2, c1, c0}), ref12);
        end
        chain_en = 0;

        // R2: modulo-N divider via decoded synchronous reset
        rst_d = 1; exp = 0;
        for (int i = 0; i < 5 * DIV_N; i++) begin
            tick();
            exp = (exp + 1) % DIV_N;
            chk(cnt_d == 4'(exp), "R2 divider sequence", cnt_d, exp);
        end

        finish_up();
    end

endmodule